// File: doc/BRIEF.md
# Output-Compare Pulse Train Timer

The block is a 16-bit free-running timebase with a power-of-two prescaler and eight output-compare channels. Each channel compares a programmed value against the counter. On a match it raises a sticky flag, can drive its own pin high, low or toggle it, and requests an interrupt when enabled. The highest channel is a master compare. When it matches, it forces every pin selected by a mask register to the level held in a data register. The forced level overrides the pin's own action.

A common use pairs the master channel with another channel to make a pulse train. The master match pulls the shared pin low and the second channel's match drives it high. Software advances both compare values after each match. Everything is configured through a simple register write port.

Top module: `oc_pulse_timer`

## Requirements
- R1: Bit 7 of the system control register at address 7 enables the timebase. While that bit is clear the counter keeps its value.
- R2: Bits 2:0 of the register at address 8 hold a prescale code k. The counter then advances once every 2^k clocks: code 0 gives every clock and code 2 gives every fourth clock.
- R3: While enabled, the 16-bit counter advances by exactly one per prescaled tick and wraps from 0xFFFF to 0.
- R4: The compare value of channel c is written at address 16+c. A channel's flag bit becomes 1 on the same clock edge at which the counter takes the channel's compare value.
- R5: Writing the flag register (address 6) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A match in the same cycle as a clear leaves the flag set.
- R6: Each channel has a 2-bit pin action: 00 leaves the pin alone, 01 toggles it, 10 drives it low, 11 drives it high. Channels 7..4 use address 1 and channels 3..0 use address 2, with channel c in bits [2*(c%4)+1 : 2*(c%4)]. Channel 6 therefore uses bits 5:4 of address 1.
- R7: Bit c of the select register (address 0) makes channel c an output compare. With that bit clear the channel neither sets its flag nor changes its pin on a match.
- R8: Interrupt request c is flag c AND enable bit c of the register at address 5.
- R9: On a channel 7 match, every pin whose bit is set in the mask register (address 3) takes the matching bit of the data register (address 4).
- R10: When channel 7 and another channel match on the same count, the channel 7 mask/data level wins on a masked pin. The other channel still sets its flag.
- R11: A compare fires once per prescaled tick. While the counter rests on the compare value between ticks, a cleared flag stays clear.
- R12: After reset the counter, flags, interrupt requests and pins are all 0, and the timebase is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| flag_o | output | 8 | Channel flags |
| irq_o | output | 8 | Channel interrupt requests |
| pin_o | output | 8 | Channel pins |

## Verification
The hardest case to reach from the ports is a match that lands while the counter rests between prescaled ticks. Only that case shows whether a compare repeats on every clock. The stimulus sets the prescale code to 2 and waits for the counter to reach the compare value. It then clears the flag and checks, a clock later, that the counter still sits on the value and the flag stays clear. A second hard case is the same-count collision between the master and another channel. The bench reaches it by loading both compare registers with the same future count, with the shared pin masked.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  typedef enum logic [1:0] {
    PA_NONE   = 2'b00,
    PA_TOGGLE = 2'b01,
    PA_LOW    = 2'b10,
    PA_HIGH   = 2'b11
  } pin_act_e;

  localparam int unsigned A_SEL   = 0;
  localparam int unsigned A_CTRL  = 1;
  localparam int unsigned A_MASK  = 3;
  localparam int unsigned A_MDATA = 4;
  localparam int unsigned A_IE    = 5;
  localparam int unsigned A_FLAG  = 6;
  localparam int unsigned A_SYS1  = 7;
  localparam int unsigned A_SYS2  = 8;
  localparam int unsigned A_CMP   = 16;
  localparam int unsigned EN_BIT  = 7;
endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [PSW-1:0] psc_i,
  output logic           tick_o,
  output logic [CW-1:0]  cnt_o,
  output logic [CW-1:0]  cnt_nxt_o
);
  localparam int unsigned PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pre_q, pre_mask;
  logic [CW-1:0]  cnt_q;

  assign pre_mask  = (PCW'(1) << psc_i) - PCW'(1);
  assign tick_o    = en_i && ((pre_q & pre_mask) == pre_mask);
  assign cnt_nxt_o = cnt_q + CW'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (en_i)   pre_q <= pre_q + PCW'(1);
      if (tick_o) cnt_q <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int unsigned CW = 16
) (
  input  logic          tick_i,
  input  logic          oc_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] cmp_i,
  output logic          hit_o
);
  // compare against the value the counter takes on this tick
  assign hit_o = tick_i && oc_i && (cnt_nxt_i == cmp_i);
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
  import oc_timer_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCH-1:0]      hit_i,
  input  logic [NCH-1:0][1:0] act_i,
  input  logic [NCH-1:0]      mask_i,
  input  logic [NCH-1:0]      mdata_i,
  output logic [NCH-1:0]      pin_o
);
  localparam int unsigned MST = NCH - 1;

  logic [NCH-1:0] pin_q, pin_d;

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    always_comb begin
      pin_d[i] = pin_q[i];
      if (hit_i[i]) begin
        unique case (pin_act_e'(act_i[i]))
          PA_TOGGLE: pin_d[i] = ~pin_q[i];
          PA_LOW:    pin_d[i] = 1'b0;
          PA_HIGH:   pin_d[i] = 1'b1;
          default:   pin_d[i] = pin_q[i];
        endcase
      end
      // master override has priority
      if (hit_i[MST] && mask_i[i]) pin_d[i] = mdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/oc_pulse_timer.sv
module oc_pulse_timer
  import oc_timer_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 16,
  parameter int unsigned PSW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] cnt_o,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] pin_o
);
  localparam int unsigned NCTRL = NCH / 4;
  localparam logic [AW-1:0] ADR_SEL   = AW'(A_SEL);
  localparam logic [AW-1:0] ADR_MASK  = AW'(A_MASK);
  localparam logic [AW-1:0] ADR_MDATA = AW'(A_MDATA);
  localparam logic [AW-1:0] ADR_IE    = AW'(A_IE);
  localparam logic [AW-1:0] ADR_FLAG  = AW'(A_FLAG);
  localparam logic [AW-1:0] ADR_SYS1  = AW'(A_SYS1);
  localparam logic [AW-1:0] ADR_SYS2  = AW'(A_SYS2);

  logic [NCH-1:0]         sel_q, mask_q, mdata_q, ie_q, flag_q, hit, clr;
  logic [NCH-1:0][1:0]    act_q;
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic                   en_q, tick;
  logic [PSW-1:0]         psc_q;
  logic [CW-1:0]          cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      mask_q  <= '0;
      mdata_q <= '0;
      ie_q    <= '0;
      act_q   <= '0;
      cmp_q   <= '0;
      en_q    <= 1'b0;
      psc_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADR_SEL)   sel_q   <= wr_data_i[NCH-1:0];
      if (wr_addr_i == ADR_MASK)  mask_q  <= wr_data_i[NCH-1:0];
      if (wr_addr_i == ADR_MDATA) mdata_q <= wr_data_i[NCH-1:0];
      if (wr_addr_i == ADR_IE)    ie_q    <= wr_data_i[NCH-1:0];
      if (wr_addr_i == ADR_SYS1)  en_q    <= wr_data_i[EN_BIT];
      if (wr_addr_i == ADR_SYS2)  psc_q   <= wr_data_i[PSW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr_i == AW'(A_CTRL + (NCTRL - 1 - c / 4)))
          act_q[c] <= wr_data_i[2*(c%4) +: 2];
        if (wr_addr_i == AW'(A_CMP + c))
          cmp_q[c] <= wr_data_i[CW-1:0];
      end
    end
  end

  assign clr = (wr_en_i && wr_addr_i == ADR_FLAG) ? wr_data_i[NCH-1:0] : '0;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr) | hit;
  end

  oc_timebase #(.CW(CW), .PSW(PSW)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .psc_i     (psc_q),
    .tick_o    (tick),
    .cnt_o     (cnt_o),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    oc_match #(.CW(CW)) u_match (
      .tick_i    (tick),
      .oc_i      (sel_q[c]),
      .cnt_nxt_i (cnt_nxt),
      .cmp_i     (cmp_q[c]),
      .hit_o     (hit[c])
    );
  end

  oc_pin_unit #(.NCH(NCH)) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .act_i   (act_q),
    .mask_i  (mask_q),
    .mdata_i (mdata_q),
    .pin_o   (pin_o)
  );

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/oc_pulse_timer_chk.sv
module oc_pulse_timer_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [AW-1:0]  wr_addr_i,
  input logic [DW-1:0]  wr_data_i,
  input logic [CW-1:0]  cnt_o,
  input logic [NCH-1:0] flag_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] pin_o,
  input logic           en_q,
  input logic [NCH-1:0] sel_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] mdata_q
);
  a_r1_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(cnt_o));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CW'(1)));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r4_flag_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> cnt_o != $past(cnt_o));

    a_r7_ic_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(sel_q[i]));

    a_r5_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[i]) |-> $past(wr_en_i && wr_addr_i == AW'(6) && wr_data_i[i]));

    a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> flag_o[i]);

    a_r10_master_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flag_o[NCH-1]) && $past(mask_q[i])) |-> pin_o[i] == $past(mdata_q[i]));
  end
endmodule

bind oc_pulse_timer oc_pulse_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .cnt_o     (cnt_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .pin_o     (pin_o),
  .en_q      (en_q),
  .sel_q     (sel_q),
  .mask_q    (mask_q),
  .mdata_q   (mdata_q)
);

// File: tb/oc_pulse_timer_tb_top.sv
`timescale 1ns/1ps
module oc_pulse_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic [7:0]  flag, irq, pin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  oc_pulse_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt_o(cnt), .flag_o(flag), .irq_o(irq), .pin_o(pin)
  );

  // {oc, ch[2:0], action[1:0], expected pin}
  localparam logic [6:0] VEC [8] = '{
    7'b1_000_11_1, 7'b1_000_01_0, 7'b1_000_01_1, 7'b1_000_10_0,
    7'b1_011_00_0, 7'b1_010_01_1, 7'b0_010_11_1, 7'b1_101_11_1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int n = 0;
    while (cnt !== v && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) check("wait timeout", 32'(cnt), 32'(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] t, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state, R1 disabled after reset
    check("R12 cnt", 32'(cnt), 0);
    check("R12 flag", 32'(flag), 0);
    check("R12 irq", 32'(irq), 0);
    check("R12 pin", 32'(pin), 0);

    wr(5'd7, 16'h0080);
    @(negedge clk); c0 = cnt;
    @(negedge clk);
    check("R3 step by one at code 0", 32'(cnt), 32'(c0 + 16'd1));

    // R6/R7/R4: vector walk
    foreach (VEC[k]) begin
      logic       oc;
      logic [2:0] ch;
      logic [1:0] act;
      logic       ep;
      {oc, ch, act, ep} = VEC[k];
      wr(5'd0, 16'(oc) << ch);
      wr(ch >= 3'd4 ? 5'd1 : 5'd2, 16'(act) << (2 * (ch % 4)));
      wr(5'd6, 16'h00FF);
      t = cnt + 16'd20;
      wr(5'd16 + 5'(ch), t);
      wait_cnt(t - 16'd1);
      check("R4 flag before match", 32'(flag[ch]), 0);
      wait_cnt(t);
      check(oc ? "R4 flag at match" : "R7 capture channel no flag", 32'(flag[ch]), 32'(oc));
      check(oc ? "R6 pin action" : "R7 capture channel pin kept", 32'(pin[ch]), 32'(ep));
    end

    // R8 interrupt gating, R5 clear semantics (flag 5 set now)
    wr(5'd5, 16'h0000);
    check("R8 irq masked", 32'(irq[5]), 0);
    wr(5'd5, 16'h0020);
    check("R8 irq enabled", 32'(irq[5]), 1);
    wr(5'd6, 16'h0000);
    check("R5 zero write keeps flag", 32'(flag[5]), 1);
    wr(5'd6, 16'h0020);
    check("R5 one write clears flag", 32'(flag[5]), 0);
    wr(5'd5, 16'h0000);

    // R9 pulse train on pin 6: ch6 drives high, ch7 mask forces low
    wr(5'd0, 16'h00C0);
    wr(5'd1, 16'h0030);
    wr(5'd3, 16'h0040);
    wr(5'd4, 16'h0000);
    wr(5'd6, 16'h00FF);
    t = cnt + 16'd30;
    wr(5'd22, t);
    wr(5'd23, t + 16'd20);
    wait_cnt(t);
    check("R9 pin high on ch6 match", 32'(pin[6]), 1);
    wait_cnt(t + 16'd20);
    check("R9 mask forces pin low", 32'(pin[6]), 0);
    check("R9 master flag", 32'(flag[7]), 1);

    // R10 same-count collision
    wr(5'd6, 16'h00FF);
    t = cnt + 16'd30;
    wr(5'd22, t);
    wr(5'd23, t);
    wait_cnt(t);
    check("R10 master wins on masked pin", 32'(pin[6]), 0);
    check("R10 other channel flag still set", 32'(flag[6]), 1);
    wr(5'd3, 16'h0000);

    // R1 hold when disabled
    wr(5'd7, 16'h0000);
    c0 = cnt;
    repeat (10) @(negedge clk);
    check("R1 counter holds when disabled", 32'(cnt), 32'(c0));

    // R2 prescale code 2
    wr(5'd8, 16'h0002);
    wr(5'd7, 16'h0080);
    c0 = cnt;
    while (cnt == c0) @(negedge clk);
    c0 = cnt;
    begin
      int n = 0;
      while (cnt == c0 && n < 50) begin
        @(negedge clk);
        n++;
      end
      check("R2 divide by 4 interval", 32'(n), 4);
    end

    // R11 no repeat while counter rests on the compare value
    wr(5'd0, 16'h0002);
    wr(5'd2, 16'h0000);
    wr(5'd6, 16'h00FF);
    t = cnt + 16'd6;
    wr(5'd17, t);
    wait_cnt(t);
    check("R11 flag at match", 32'(flag[1]), 1);
    wr(5'd6, 16'h0002);
    @(negedge clk);
    check("R11 counter still on value", 32'(cnt), 32'(t));
    check("R11 no repeat match", 32'(flag[1]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule